// File: doc/BRIEF.md
# Master Security Interrupt Aggregator

This block is the slice of a security controller that looks after a group of bus-master security gates, by default sixteen of them. Each gate reports a rejected transaction on its own status line. The aggregator shows those lines in a read-only status word. A secure enable word selects which channels may raise the one combined interrupt. Secure software clears a channel by writing ones to a clear word. Each one becomes a single-cycle pulse on that channel's clear line. The gate then drops its status line.

The aggregator also holds a per-channel non-secure configuration word. Each bit drives an attribute line that tells the gate whether its master counts as non-secure. After reset every master is secure.

The block has an APB-style register port with no wait states. The status lines come in as a plain vector. The clear, attribute and interrupt lines go out as plain vectors.

Top module: `msc_irq_agg`

## Requirements
- R1: A read at byte offset 0x00 returns the live level of `status_i` in bits NUM_CH-1:0, with zeros above.
- R2: Offset 0x04 is the enable word. Writes store bits NUM_CH-1:0 and drop the higher bits. Reads return the stored bits with zeros above.
- R3: `irq_o` is high in any cycle where some channel n has both `status_i[n]` and enable bit n set. The output has no register stage, so a new enable value acts from the clock edge that stores it.
- R4: A write at offset 0x08 sets `clear_o[n]` high for exactly one cycle for every bit n written as 1. The pulse starts in the cycle after the access phase. Bits written as 0 give no pulse. Channels with no pulse keep `clear_o` low.
- R5: A read at offset 0x08 returns zero.
- R6: Offset 0x0C is the non-secure configuration word. It can be read and written in the same way as R2. `ns_o[n]` equals its bit n, and a value of 1 means non-secure.
- R7: Reads return zero at any address other than 0x00, 0x04, 0x08 and 0x0C, including addresses whose two low bits are not zero. Writes to those addresses change no register and produce no pulse.
- R8: During reset and after it, the enable and non-secure words are zero. `clear_o` and `ns_o` are low. `irq_o` stays low whatever the status lines do.
- R9: A write acts only in the access phase, when `psel`, `penable` and `pwrite` are all high. A setup phase alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while `psel` is high |
| status_i | input | NUM_CH | Rejected-transaction level from each gate |
| irq_o | output | 1 | Combined interrupt |
| clear_o | output | NUM_CH | Per-channel clear pulse |
| ns_o | output | NUM_CH | Per-channel non-secure attribute |

## Verification
Two events can fall in the same clock edge. One is a software write to the enable word. The other is a status line rising. The bench raises `status_i[0]` at the same moment the access phase of an enable write begins. It requires `irq_o` to stay low until the storing edge and to go high right after that edge.

A second clash pairs a clear pulse with a status line that is still high. The block does not drop the interrupt by itself in that case. The bench checks that `irq_o` stays asserted while the pulse is out, because only the gate can drop its line.

// File: rtl/msc_irq_pkg.sv
package msc_irq_pkg;

  // Word select of the four mapped registers (paddr[3:2])
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_NS   = 2'd3
  } reg_sel_e;

  localparam logic [3:0] OFF_STAT = 4'h0;
  localparam logic [3:0] OFF_EN   = 4'h4;
  localparam logic [3:0] OFF_CLR  = 4'h8;
  localparam logic [3:0] OFF_NS   = 4'hC;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } reg_dec_t;

endpackage

// File: rtl/msc_irq_regdec.sv
module msc_irq_regdec
  import msc_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_dec_t          dec,
  output logic              wr_en
);

  logic upper_zero;

  // Only word-aligned addresses below 0x10 are mapped
  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_zero = (paddr[ADDR_W-1:4] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    dec.hit = upper_zero && (paddr[1:0] == 2'b00);
    dec.sel = reg_sel_e'(paddr[3:2]);
  end

  assign wr_en = psel && penable && pwrite && dec.hit;

endmodule

// File: rtl/msc_irq_ctrl_regs.sv
module msc_irq_ctrl_regs
  import msc_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] ns_q,
  output logic [NUM_CH-1:0] clr_q
);

  logic [NUM_CH-1:0] wbits;
  logic              wr_en_reg;
  logic              wr_ns_reg;
  logic              wr_clr_reg;

  assign wbits      = wdata[NUM_CH-1:0];
  assign wr_en_reg  = wr_en && (sel == SEL_EN);
  assign wr_ns_reg  = wr_en && (sel == SEL_NS);
  assign wr_clr_reg = wr_en && (sel == SEL_CLR);

  generate
    if (DATA_W > NUM_CH) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:NUM_CH];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ns_q <= '0;
    end else begin
      if (wr_en_reg) en_q <= wbits;
      if (wr_ns_reg) ns_q <= wbits;
    end
  end

  // One pulse flop per channel: high for the single cycle after a 1 is written
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q[ch] <= 1'b0;
        else        clr_q[ch] <= wr_clr_reg && wbits[ch];
      end
    end
  endgenerate

endmodule

// File: rtl/msc_irq_combine.sv
module msc_irq_combine
  import msc_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic              psel,
  input  reg_dec_t          dec,
  input  logic [NUM_CH-1:0] status,
  input  logic [NUM_CH-1:0] en_q,
  input  logic [NUM_CH-1:0] ns_q,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_CH-1:0] word;

  assign irq = |(status & en_q);

  always_comb begin
    word = '0;
    if (psel && dec.hit) begin
      unique case (dec.sel)
        SEL_STAT: word = status;
        SEL_EN:   word = en_q;
        SEL_CLR:  word = '0;
        SEL_NS:   word = ns_q;
      endcase
    end
  end

  generate
    if (DATA_W > NUM_CH) begin : g_pad
      assign rdata = {{(DATA_W-NUM_CH){1'b0}}, word};
    end else begin : g_nopad
      assign rdata = word;
    end
  endgenerate

endmodule

// File: rtl/msc_irq_agg.sv
module msc_irq_agg
  import msc_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NUM_CH-1:0] status_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] clear_o,
  output logic [NUM_CH-1:0] ns_o
);

  reg_dec_t          dec;
  logic              wr_en;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] ns_q;
  logic [NUM_CH-1:0] clr_q;

  msc_irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .dec     (dec),
    .wr_en   (wr_en)
  );

  msc_irq_ctrl_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (dec.sel),
    .wdata (pwdata),
    .en_q  (en_q),
    .ns_q  (ns_q),
    .clr_q (clr_q)
  );

  msc_irq_combine #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_comb (
    .psel   (psel),
    .dec    (dec),
    .status (status_i),
    .en_q   (en_q),
    .ns_q   (ns_q),
    .irq    (irq_o),
    .rdata  (prdata)
  );

  assign clear_o = clr_q;
  assign ns_o    = ns_q;

endmodule

// File: rtl/msc_irq_agg_chk.sv
module msc_irq_agg_chk
  import msc_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [NUM_CH-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [NUM_CH-1:0] status_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] clear_o,
  input logic [NUM_CH-1:0] ns_o
);

  logic acc_wr, wr_clr, wr_ns, rd_clr, mapped, seen_rst;

  assign acc_wr = psel && penable && pwrite;
  assign wr_clr = acc_wr && (paddr == ADDR_W'(OFF_CLR));
  assign wr_ns  = acc_wr && (paddr == ADDR_W'(OFF_NS));
  assign rd_clr = psel && !pwrite && (paddr == ADDR_W'(OFF_CLR));
  assign mapped = (paddr == ADDR_W'(OFF_STAT)) || (paddr == ADDR_W'(OFF_EN)) ||
                  (paddr == ADDR_W'(OFF_CLR))  || (paddr == ADDR_W'(OFF_NS));

  always_ff @(posedge clk) seen_rst <= seen_rst || !rst_n;

  assert_clear_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (clear_o == $past(pwdata)));

  assert_clear_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> (clear_o == '0));

  assert_ns_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ns |=> $stable(ns_o));

  assert_irq_needs_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|status_i));

  assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |-> (prdata == '0));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && !mapped) |-> (prdata == '0));

  assert_reset_outputs_R8: assert property (@(posedge clk)
    (!rst_n && seen_rst) |-> (ns_o == '0 && clear_o == '0 && !irq_o));

endmodule

bind msc_irq_agg msc_irq_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata[NUM_CH-1:0]),
  .prdata   (prdata),
  .status_i (status_i),
  .irq_o    (irq_o),
  .clear_o  (clear_o),
  .ns_o     (ns_o)
);

// File: tb/msc_irq_agg_tb_top.sv
`timescale 1ns/1ps
module msc_irq_agg_tb_top;

  localparam int NCH = 16;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic [NCH-1:0] status_i = '0;
  logic          irq_o;
  logic [NCH-1:0] clear_o, ns_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msc_irq_agg #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .status_i(status_i),
    .irq_o(irq_o), .clear_o(clear_o), .ns_o(ns_o)
  );

  typedef struct packed {
    logic           wr;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;   // write data, or expected read data
    logic [NCH-1:0] stat;
    logic           irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h004, 32'h0000_00FF, 16'h0000, 1'b0},
    '{1'b0, 12'h000, 32'h0000_0101, 16'h0101, 1'b1},
    '{1'b0, 12'h004, 32'h0000_00FF, 16'h0100, 1'b0},
    '{1'b1, 12'h004, 32'hFFFF_0F00, 16'h0100, 1'b1},
    '{1'b0, 12'h004, 32'h0000_0F00, 16'h8000, 1'b0},
    '{1'b1, 12'h00C, 32'h0000_A5A5, 16'h0000, 1'b0},
    '{1'b0, 12'h00C, 32'h0000_A5A5, 16'h0000, 1'b0},
    '{1'b0, 12'h008, 32'h0000_0000, 16'h0F00, 1'b1},
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 16'h0000, 1'b0},
    '{1'b0, 12'h010, 32'h0000_0000, 16'h0000, 1'b0},
    '{1'b0, 12'h005, 32'h0000_0000, 16'h0000, 1'b0},
    '{1'b1, 12'h006, 32'h0000_FFFF, 16'h0000, 1'b0},
    '{1'b0, 12'h004, 32'h0000_0F00, 16'h0000, 1'b0},
    '{1'b1, 12'h004, 32'h0000_FFFF, 16'hFFFF, 1'b1},
    '{1'b0, 12'h000, 32'h0000_FFFF, 16'hFFFF, 1'b1}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [AW-1:0] a);
    case (a)
      12'h000: return "R1";
      12'h004: return "R2";
      12'h008: return "R5";
      12'h00C: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Two-phase transfer; returns at the falling edge after the storing edge
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1 rd = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    // Reset state: R8
    status_i = '1;
    repeat (3) @(negedge clk);
    check("R8 ns_o in reset", {16'h0, ns_o}, 32'h0);
    check("R8 irq in reset", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 clear_o after reset", {16'h0, clear_o}, 32'h0);
    check("R8 irq with all status", {31'h0, irq_o}, 32'h0);
    xfer(1'b0, 12'h004, '0, rd);
    check("R8 enable reset value", rd, 32'h0);
    status_i = '0;

    // Vector table: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      status_i = VECS[i].stat;
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].data, rd);
      if (!VECS[i].wr) check(req_of(VECS[i].addr), rd, VECS[i].data);
      #1 check("R3 irq", {31'h0, irq_o}, {31'h0, VECS[i].irq});
    end
    check("R6 ns_o follows config", {16'h0, ns_o}, 32'h0000_A5A5);
    check("R7 no pulse from unmapped write", {16'h0, clear_o}, 32'h0);

    // R9: setup phase only, no access phase
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h00C; pwdata = 32'h0;
    repeat (2) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    check("R9 setup-only write ignored", {16'h0, ns_o}, 32'h0000_A5A5);

    // Same-edge clash: enable write stored while status rises (R3)
    xfer(1'b1, 12'h004, 32'h0, rd);
    status_i = '0;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h004; pwdata = 32'h1;
    @(negedge clk);
    penable = 1'b1; status_i = 16'h0001;
    #1 check("R3 irq before storing edge", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1 check("R3 irq after storing edge", {31'h0, irq_o}, 32'h1);

    // Clear pulse while status still high (R4, R3)
    xfer(1'b1, 12'h004, 32'h8, rd);
    status_i = 16'h0008;
    xfer(1'b1, 12'h008, 32'h8, rd);
    check("R4 pulse on channel 3", {16'h0, clear_o}, 32'h8);
    check("R3 irq held by live status", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    check("R4 pulse lasts one cycle", {16'h0, clear_o}, 32'h0);
    xfer(1'b1, 12'h008, 32'hFFFF_00F0, rd);
    check("R4 multi-bit pulse", {16'h0, clear_o}, 32'h00F0);
    xfer(1'b1, 12'h008, 32'h0, rd);
    check("R4 zero write no pulse", {16'h0, clear_o}, 32'h0);
    xfer(1'b0, 12'h004, '0, rd);
    check("R4 clear leaves enable", rd, 32'h8);

    // Reset mid-run clears state (R8)
    @(negedge clk);
    rst_n = 1'b0;
    status_i = '1;
    #1 check("R8 ns_o cleared", {16'h0, ns_o}, 32'h0);
    check("R8 irq cleared", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule